// File: doc/BRIEF.md
# Word-to-Byte Sector Packer

This block converts between 12-bit memory words and the 8-bit byte stream of a disk sector that holds 256 bytes. It has two packing modes. In byte mode each word carries one byte in its low eight bits. In packed mode each pair of words becomes a group of three bytes, and the middle byte holds one nibble from each word. A sector in packed mode therefore holds 170 words and one spare byte.

A transfer starts with a one-cycle `start` strobe. With the strobe come the direction, the mode, the word-count register and the starting sector. The word-count register holds the negated count in 12-bit two's complement. The block latches a transfer plan that gives the number of words and the number of data bytes. Packed transfers are limited to one sector. Byte-mode transfers are limited to the end of the 40-sector track. The block then moves data over valid/ready streams.

A write takes words in and sends bytes out. It zero-fills the last sector up to the sector boundary. A read takes bytes in and sends words out. When the byte source is flagged empty, every missing byte counts as zero. `busy` covers the transfer, and `done` pulses once when it ends.

Top module: `wordbyte_packer`

## Requirements
- R1: The true word count is 4096 minus `wcount_in`, so a register value of 0 means 4096 words. This count shows on `xfer_words` when it is not capped.
- R2: In packed mode (`mode8`=0) the byte count is floor((3·words+1)/2). If that exceeds 256, the plan becomes 256 bytes and 170 words.
- R3: In byte mode (`mode8`=1) the byte count equals the word count, limited to (40 − `sector_in`)·256. A sector of 40 or more gives a zero-length transfer that still ends with `done`.
- R4: A packed write of even word E and odd word O emits byte0 = E[7:0], byte1 = {O[3:0], E[11:8]} (bits 7:4 from O) and byte2 = O[11:4]. When a final even word has no partner, bits 7:4 of its byte1 are 0.
- R5: A byte-mode write emits each word's bits 7:0 as one byte. Bits 11:8 are dropped.
- R6: A write emits exactly the data bytes rounded up to a multiple of 256, and nothing when the plan is empty. Every byte past the data bytes, including the spare byte of a capped packed sector, is 0.
- R7: A packed read rebuilds even word = {byte1[3:0], byte0} and odd word = {byte2, byte1[7:4]}. A final unpaired word ignores byte1[7:4]. In a capped sector the 256th byte is consumed and no word comes from it.
- R8: A byte-mode read emits each word as {4'b0000, byte}.
- R9: While `src_empty` is high, each byte the read needs counts as zero, and `b_in_ready` stays low.
- R10: `busy` rises the cycle after an accepted `start`. `busy` falls and `done` pulses high for exactly one cycle after the last handshake. A `start` while busy is ignored.
- R11: After reset `busy`, `done`, `xfer_words`, `xfer_bytes` and every stream valid/ready output are 0. Stream outputs stay 0 while idle.
- R12: A write accepts exactly the planned number of words. A read accepts exactly the planned number of data bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (ignored while busy) |
| wr_dir | input | 1 | 1 = write (words to bytes), 0 = read (bytes to words) |
| mode8 | input | 1 | 1 = byte mode, 0 = packed mode |
| wcount_in | input | 12 | Negated word count, two's complement |
| sector_in | input | 6 | Starting sector within the track |
| src_empty | input | 1 | Read source exhausted: missing bytes count as zero |
| w_in_valid | input | 1 | Write word valid |
| w_in_data | input | 12 | Write word |
| w_in_ready | output | 1 | Write word accepted |
| b_out_valid | output | 1 | Outgoing byte valid |
| b_out_data | output | 8 | Outgoing byte |
| b_out_ready | input | 1 | Byte sink ready |
| b_in_valid | input | 1 | Incoming byte valid |
| b_in_data | input | 8 | Incoming byte |
| b_in_ready | output | 1 | Incoming byte accepted |
| w_out_valid | output | 1 | Read word valid |
| w_out_data | output | 12 | Read word |
| w_out_ready | input | 1 | Word sink ready |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| xfer_words | output | 13 | Planned word count |
| xfer_bytes | output | 14 | Planned data byte count |

## Verification
A sweep of packed reads from an empty source covers word counts 1 to 180 and 4096. It finds any error in the (3n+1)/2 rounding, the point where the 170-word cap takes effect, and any byte that is not zero-substituted. Byte-mode runs from sectors 0, 38, 39, 40 and 63 separate the word-count limit from the track-end limit and the empty case. Packed writes and reads with 1, 2, 3, 5, 170 and 171 words cover odd partial groups, full groups and the spare byte, each checked byte for byte against an arithmetic model. Ready and valid are throttled in different rhythms, and a stray `start` mid-transfer shows whether the latched plan is disturbed.

// File: rtl/wbp_pkg.sv
package wbp_pkg;

    localparam int WORD_W        = 12;
    localparam int BYTE_W        = 8;
    localparam int NIB_W         = WORD_W - BYTE_W;
    localparam int SECT_BYTES    = 256;
    localparam int TRACK_SECTORS = 40;
    localparam int SECT_W        = 6;
    localparam int WCNT_W        = WORD_W + 1;
    localparam int BCNT_W        = $clog2(TRACK_SECTORS * SECT_BYTES + 1);
    localparam int CAP12_WORDS   = (SECT_BYTES * 2) / 3;

    typedef struct packed {
        logic [WCNT_W-1:0] words;
        logic [BCNT_W-1:0] bytes;
        logic [BCNT_W-1:0] span;
    } xfer_plan_t;

    typedef enum logic [1:0] {
        GRP_B0 = 2'd0,
        GRP_B1 = 2'd1,
        GRP_B2 = 2'd2
    } grp_phase_t;

    function automatic grp_phase_t next_phase(input grp_phase_t ph);
        case (ph)
            GRP_B0:  return GRP_B1;
            GRP_B1:  return GRP_B2;
            default: return GRP_B0;
        endcase
    endfunction

    function automatic xfer_plan_t plan_xfer(
        input logic [WORD_W-1:0] wc_reg,
        input logic              pack8,
        input logic [SECT_W-1:0] sector
    );
        int w;
        int b;
        int lim;
        xfer_plan_t p;
        w = (1 << WORD_W) - int'(wc_reg);
        if (pack8) begin
            lim = (int'(sector) < TRACK_SECTORS) ?
                  (TRACK_SECTORS - int'(sector)) * SECT_BYTES : 0;
            b = (w < lim) ? w : lim;
            w = b;
        end else begin
            b = (3 * w + 1) / 2;
            if (b > SECT_BYTES) begin
                b = SECT_BYTES;
                w = CAP12_WORDS;
            end
        end
        p.words = WCNT_W'(w);
        p.bytes = BCNT_W'(b);
        p.span  = BCNT_W'(((b + SECT_BYTES - 1) / SECT_BYTES) * SECT_BYTES);
        return p;
    endfunction

endpackage

// File: rtl/wbp_sizer.sv
module wbp_sizer
    import wbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic [WORD_W-1:0] wc_reg,
    input  logic              pack8,
    input  logic [SECT_W-1:0] sector,
    output xfer_plan_t        plan
);

    always_ff @(posedge clk) begin
        if (rst) begin
            plan <= '0;
        end else if (launch) begin
            plan <= plan_xfer(wc_reg, pack8, sector);
        end
    end

    AST_PACKED_CAP: assert property (@(posedge clk) disable iff (rst)
        launch && !pack8 |=> plan.bytes <= BCNT_W'(SECT_BYTES)); // R2

    AST_BYTE_MODE_EQ: assert property (@(posedge clk) disable iff (rst)
        launch && pack8 |=> BCNT_W'(plan.words) == plan.bytes); // R3

    AST_SPAN_COVERS: assert property (@(posedge clk) disable iff (rst)
        launch |=> plan.span >= plan.bytes); // R6

endmodule

// File: rtl/wbp_word2byte.sv
module wbp_word2byte
    import wbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              run,
    input  logic              pack8,
    input  logic [WCNT_W-1:0] plan_words,
    input  logic [BCNT_W-1:0] plan_bytes,
    input  logic [BCNT_W-1:0] plan_span,
    input  logic              w_in_valid,
    input  logic [WORD_W-1:0] w_in_data,
    output logic              w_in_ready,
    output logic              b_out_valid,
    output logic [BYTE_W-1:0] b_out_data,
    input  logic              b_out_ready,
    output logic              finished
);

    logic [BCNT_W-1:0] byte_cnt;
    logic [WCNT_W-1:0] word_cnt;
    grp_phase_t        phase;
    logic [NIB_W-1:0]  hold_nib;
    logic [BYTE_W-1:0] hold_byte;

    logic              have_word;
    logic              in_data;
    logic              need_word;
    logic              emit;
    logic              step;
    logic              take;
    logic [BYTE_W-1:0] byte_val;

    always_comb begin
        have_word = word_cnt < plan_words;
        in_data   = byte_cnt < plan_bytes;
        finished  = byte_cnt == plan_span;
        emit      = run && !finished;
        need_word = 1'b0;
        byte_val  = '0;
        if (in_data) begin
            if (pack8) begin
                need_word = 1'b1;
                byte_val  = w_in_data[BYTE_W-1:0];
            end else begin
                case (phase)
                    GRP_B0: begin
                        if (have_word) begin
                            need_word = 1'b1;
                            byte_val  = w_in_data[BYTE_W-1:0];
                        end
                    end
                    GRP_B1: begin
                        if (have_word) begin
                            need_word = 1'b1;
                            byte_val  = {w_in_data[NIB_W-1:0], hold_nib};
                        end else begin
                            byte_val  = {{NIB_W{1'b0}}, hold_nib};
                        end
                    end
                    default: byte_val = hold_byte;
                endcase
            end
        end
        b_out_valid = emit && (!need_word || w_in_valid);
        w_in_ready  = emit && need_word && b_out_ready;
        b_out_data  = byte_val;
        step        = b_out_valid && b_out_ready;
        take        = w_in_valid && w_in_ready;
    end

    always_ff @(posedge clk) begin
        if (rst || launch) begin
            byte_cnt  <= '0;
            word_cnt  <= '0;
            phase     <= GRP_B0;
            hold_nib  <= '0;
            hold_byte <= '0;
        end else if (step) begin
            byte_cnt <= byte_cnt + BCNT_W'(1);
            if (take) begin
                word_cnt <= word_cnt + WCNT_W'(1);
            end
            if (!pack8) begin
                phase <= next_phase(phase);
                if (phase == GRP_B0) begin
                    hold_nib <= take ? w_in_data[WORD_W-1:BYTE_W] : '0;
                end
                if (phase == GRP_B1 && take) begin
                    hold_byte <= w_in_data[WORD_W-1:NIB_W];
                end
            end
        end
    end

    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        b_out_valid && (byte_cnt >= plan_bytes) |-> b_out_data == '0); // R6

    AST_WORD_LIMIT: assert property (@(posedge clk) disable iff (rst)
        w_in_valid && w_in_ready |-> word_cnt < plan_words); // R12

    AST_SPAN_LIMIT: assert property (@(posedge clk) disable iff (rst)
        b_out_valid && b_out_ready |-> byte_cnt < plan_span); // R6

    AST_ALL_WORDS_TAKEN: assert property (@(posedge clk) disable iff (rst)
        run && finished |-> word_cnt == plan_words); // R12

endmodule

// File: rtl/wbp_byte2word.sv
module wbp_byte2word
    import wbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              run,
    input  logic              pack8,
    input  logic [WCNT_W-1:0] plan_words,
    input  logic [BCNT_W-1:0] plan_bytes,
    input  logic              src_empty,
    input  logic              b_in_valid,
    input  logic [BYTE_W-1:0] b_in_data,
    output logic              b_in_ready,
    output logic              w_out_valid,
    output logic [WORD_W-1:0] w_out_data,
    input  logic              w_out_ready,
    output logic              finished
);

    logic [BCNT_W-1:0] byte_cnt;
    logic [WCNT_W-1:0] word_cnt;
    grp_phase_t        phase;
    logic [BYTE_W-1:0] lo_byte;
    logic [NIB_W-1:0]  hold_nib;

    logic              avail;
    logic              act;
    logic              emits_word;
    logic              take;
    logic [BYTE_W-1:0] bval;
    logic [WORD_W-1:0] word_val;

    always_comb begin
        avail      = src_empty || b_in_valid;
        bval       = src_empty ? '0 : b_in_data;
        finished   = byte_cnt == plan_bytes;
        act        = run && !finished;
        emits_word = pack8 || (phase != GRP_B0);
        if (pack8) begin
            word_val = {{NIB_W{1'b0}}, bval};
        end else if (phase == GRP_B1) begin
            word_val = {bval[NIB_W-1:0], lo_byte};
        end else if (phase == GRP_B2) begin
            word_val = {bval, hold_nib};
        end else begin
            word_val = '0;
        end
        w_out_valid = act && avail && emits_word;
        w_out_data  = word_val;
        take        = act && avail && (!emits_word || w_out_ready);
        b_in_ready  = act && !src_empty && (!emits_word || w_out_ready);
    end

    always_ff @(posedge clk) begin
        if (rst || launch) begin
            byte_cnt <= '0;
            word_cnt <= '0;
            phase    <= GRP_B0;
            lo_byte  <= '0;
            hold_nib <= '0;
        end else if (take) begin
            byte_cnt <= byte_cnt + BCNT_W'(1);
            if (emits_word) begin
                word_cnt <= word_cnt + WCNT_W'(1);
            end
            if (!pack8) begin
                phase <= next_phase(phase);
                if (phase == GRP_B0) begin
                    lo_byte <= bval;
                end
                if (phase == GRP_B1) begin
                    hold_nib <= bval[BYTE_W-1:NIB_W];
                end
            end
        end
    end

    AST_EMPTY_NO_POP: assert property (@(posedge clk) disable iff (rst)
        src_empty |-> !b_in_ready); // R9

    AST_WORD_BOUND: assert property (@(posedge clk) disable iff (rst)
        w_out_valid && w_out_ready |-> word_cnt < plan_words); // R7

    AST_WORD_TOTAL: assert property (@(posedge clk) disable iff (rst)
        run && finished |-> word_cnt == plan_words); // R12

endmodule

// File: rtl/wordbyte_packer.sv
module wordbyte_packer
    import wbp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  wr_dir,
    input  logic                  mode8,
    input  logic [11:0]           wcount_in,
    input  logic [5:0]            sector_in,
    input  logic                  src_empty,
    input  logic                  w_in_valid,
    input  logic [11:0]           w_in_data,
    output logic                  w_in_ready,
    output logic                  b_out_valid,
    output logic [7:0]            b_out_data,
    input  logic                  b_out_ready,
    input  logic                  b_in_valid,
    input  logic [7:0]            b_in_data,
    output logic                  b_in_ready,
    output logic                  w_out_valid,
    output logic [11:0]           w_out_data,
    input  logic                  w_out_ready,
    output logic                  busy,
    output logic                  done,
    output logic [12:0]           xfer_words,
    output logic [13:0]           xfer_bytes
);

    logic       busy_q;
    logic       done_q;
    logic       dir_q;
    logic       mode_q;
    logic       launch;
    logic       run_wr;
    logic       run_rd;
    logic       wr_fin;
    logic       rd_fin;
    logic       fin;
    xfer_plan_t plan;

    assign launch = start && !busy_q;
    assign run_wr = busy_q && dir_q;
    assign run_rd = busy_q && !dir_q;
    assign fin    = dir_q ? wr_fin : rd_fin;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            dir_q  <= 1'b0;
            mode_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (launch) begin
                busy_q <= 1'b1;
                dir_q  <= wr_dir;
                mode_q <= mode8;
            end else if (busy_q && fin) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end
        end
    end

    wbp_sizer i_sizer (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .wc_reg (wcount_in),
        .pack8  (mode8),
        .sector (sector_in),
        .plan   (plan)
    );

    wbp_word2byte i_w2b (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .run         (run_wr),
        .pack8       (mode_q),
        .plan_words  (plan.words),
        .plan_bytes  (plan.bytes),
        .plan_span   (plan.span),
        .w_in_valid  (w_in_valid),
        .w_in_data   (w_in_data),
        .w_in_ready  (w_in_ready),
        .b_out_valid (b_out_valid),
        .b_out_data  (b_out_data),
        .b_out_ready (b_out_ready),
        .finished    (wr_fin)
    );

    wbp_byte2word i_b2w (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .run         (run_rd),
        .pack8       (mode_q),
        .plan_words  (plan.words),
        .plan_bytes  (plan.bytes),
        .src_empty   (src_empty),
        .b_in_valid  (b_in_valid),
        .b_in_data   (b_in_data),
        .b_in_ready  (b_in_ready),
        .w_out_valid (w_out_valid),
        .w_out_data  (w_out_data),
        .w_out_ready (w_out_ready),
        .finished    (rd_fin)
    );

    assign busy       = busy_q;
    assign done       = done_q;
    assign xfer_words = plan.words;
    assign xfer_bytes = plan.bytes;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R10

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        busy && start |=> $stable(xfer_words) && $stable(xfer_bytes)); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(w_in_ready || b_out_valid || b_in_ready || w_out_valid)); // R11

endmodule

// File: tb/test_wordbyte_packer.sv
module test_wordbyte_packer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        wr_dir = 1'b0;
    logic        mode8 = 1'b0;
    logic [11:0] wcount_in = '0;
    logic [5:0]  sector_in = '0;
    logic        src_empty = 1'b0;
    logic        w_in_valid = 1'b0;
    logic [11:0] w_in_data = '0;
    logic        w_in_ready;
    logic        b_out_valid;
    logic [7:0]  b_out_data;
    logic        b_out_ready = 1'b0;
    logic        b_in_valid = 1'b0;
    logic [7:0]  b_in_data = '0;
    logic        b_in_ready;
    logic        w_out_valid;
    logic [11:0] w_out_data;
    logic        w_out_ready = 1'b0;
    logic        busy;
    logic        done;
    logic [12:0] xfer_words;
    logic [13:0] xfer_bytes;

    always #10 clk = ~clk;

    wordbyte_packer i_wordbyte_packer (
        .clk(clk), .rst(rst), .start(start), .wr_dir(wr_dir), .mode8(mode8),
        .wcount_in(wcount_in), .sector_in(sector_in), .src_empty(src_empty),
        .w_in_valid(w_in_valid), .w_in_data(w_in_data), .w_in_ready(w_in_ready),
        .b_out_valid(b_out_valid), .b_out_data(b_out_data), .b_out_ready(b_out_ready),
        .b_in_valid(b_in_valid), .b_in_data(b_in_data), .b_in_ready(b_in_ready),
        .w_out_valid(w_out_valid), .w_out_data(w_out_data), .w_out_ready(w_out_ready),
        .busy(busy), .done(done), .xfer_words(xfer_words), .xfer_bytes(xfer_bytes)
    );

    int checks = 0;
    int failures = 0;

    int wsrc [0:4095];
    int bsrc [0:10239];
    int got_b [0:10239];
    int got_w [0:4095];

    int g_wi, g_bi, g_nb, g_nw, g_xw, g_xb;
    bit g_done, g_ready_empty, g_done_after, g_busy_after;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int e_words(input bit m8, input int n, input int sec);
        int lim;
        if (m8) begin
            lim = (sec < 40) ? (40 - sec) * 256 : 0;
            return (n < lim) ? n : lim;
        end
        return ((3 * n + 1) / 2 > 256) ? 170 : n;
    endfunction

    function automatic int e_bytes(input bit m8, input int n, input int sec);
        if (m8) return e_words(m8, n, sec);
        return ((3 * n + 1) / 2 > 256) ? 256 : (3 * n + 1) / 2;
    endfunction

    function automatic int e_wbyte(input int k, input int n, input int bc);
        int g, r, e, o, lo, hi;
        if (k >= bc) return 0;
        g = k / 3; r = k % 3; e = 2 * g; o = e + 1;
        lo = (e < n) ? wsrc[e] : 0;
        hi = (o < n) ? wsrc[o] : 0;
        if (r == 0) return lo % 256;
        if (r == 1) return (lo / 256) + (hi % 16) * 16;
        return hi / 16;
    endfunction

    function automatic int e_rword(input int j);
        int g;
        g = j / 2;
        if (j % 2 == 0) return bsrc[3 * g] + (bsrc[3 * g + 1] % 16) * 256;
        return (bsrc[3 * g + 1] / 16) + bsrc[3 * g + 2] * 16;
    endfunction

    task automatic run_xfer(input bit wr, input bit m8, input int n, input int sec,
                            input bit empty, input bit poke);
        g_wi = 0; g_bi = 0; g_nb = 0; g_nw = 0;
        g_done = 0; g_ready_empty = 0; g_xw = -1; g_xb = -1;
        @(negedge clk);
        wr_dir = wr; mode8 = m8; wcount_in = 12'(4096 - n);
        sector_in = 6'(sec); src_empty = empty; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc < 30000 && !g_done; cyc++) begin
            if (cyc > 0) @(negedge clk);
            if (poke && cyc == 3) begin
                start = 1'b1; mode8 = ~m8; wr_dir = ~wr; wcount_in = 12'hFFF;
            end else begin
                start = 1'b0;
            end
            w_in_valid  = wr && (g_wi < n + 2) && (cyc % 4 != 3);
            w_in_data   = 12'(wsrc[g_wi % 4096]);
            b_out_ready = (cyc % 3 != 2);
            b_in_valid  = !wr && !empty && (cyc % 5 != 4);
            b_in_data   = 8'(bsrc[g_bi % 10240]);
            w_out_ready = (cyc % 4 != 1);
            #5;
            if (cyc == 0) begin
                g_xw = int'(xfer_words); g_xb = int'(xfer_bytes);
            end
            if (w_in_valid && w_in_ready) g_wi++;
            if (b_in_valid && b_in_ready) g_bi++;
            if (src_empty && b_in_ready) g_ready_empty = 1;
            if (b_out_valid && b_out_ready) begin
                if (g_nb < 10240) got_b[g_nb] = int'(b_out_data);
                g_nb++;
            end
            if (w_out_valid && w_out_ready) begin
                if (g_nw < 4096) got_w[g_nw] = int'(w_out_data);
                g_nw++;
            end
            if (done) g_done = 1;
        end
        w_in_valid = 0; b_in_valid = 0; start = 0;
        @(negedge clk);
        #5;
        g_done_after = done; g_busy_after = busy;
    endtask

    task automatic do_write(input bit m8, input int n, input int sec, input bit poke);
        int ew, eb, span, bad, badk, act, exp;
        ew = e_words(m8, n, sec); eb = e_bytes(m8, n, sec);
        span = ((eb + 255) / 256) * 256;
        run_xfer(1, m8, n, sec, 0, poke);
        check(g_done, "R10 done seen", g_done, 1);
        check(g_xw == ew, m8 ? "R3 words" : "R2 words", g_xw, ew);
        check(g_xb == eb, m8 ? "R3 bytes" : "R2 bytes", g_xb, eb);
        check(g_wi == ew, "R12 words taken", g_wi, ew);
        check(g_nb == span, "R6 byte total", g_nb, span);
        bad = 0; badk = 0; act = 0; exp = 0;
        for (int k = 0; k < g_nb && k < span; k++) begin
            int e;
            if (m8) e = (k < eb) ? wsrc[k] % 256 : 0;
            else    e = e_wbyte(k, ew, eb);
            if (got_b[k] != e && !bad) begin
                bad = 1; badk = k; act = got_b[k]; exp = e;
            end
        end
        if (bad) $display("  mismatch at byte %0d", badk);
        check(!bad, m8 ? "R5 byte content" : "R4 R6 byte content", act, exp);
        check(!g_done_after && !g_busy_after, "R10 single done pulse", g_done_after, 0);
    endtask

    task automatic do_read(input bit m8, input int n, input int sec);
        int ew, eb, bad, act, exp;
        ew = e_words(m8, n, sec); eb = e_bytes(m8, n, sec);
        run_xfer(0, m8, n, sec, 0, 0);
        check(g_done, "R10 done seen", g_done, 1);
        check(g_bi == eb, "R12 bytes taken", g_bi, eb);
        check(g_nw == ew, m8 ? "R8 word total" : "R7 word total", g_nw, ew);
        bad = 0; act = 0; exp = 0;
        for (int j = 0; j < g_nw && j < ew; j++) begin
            int e;
            e = m8 ? bsrc[j] : e_rword(j);
            if (got_w[j] != e && !bad) begin
                bad = 1; act = got_w[j]; exp = e;
            end
        end
        check(!bad, m8 ? "R8 word content" : "R7 word content", act, exp);
    endtask

    task automatic do_empty(input bit m8, input int n, input int sec, input string req);
        int ew, eb, nz;
        ew = e_words(m8, n, sec); eb = e_bytes(m8, n, sec);
        run_xfer(0, m8, n, sec, 1, 0);
        check(g_done, "R10 done seen", g_done, 1);
        check(g_xw == ew, req, g_xw, ew);
        check(g_xb == eb, req, g_xb, eb);
        check(g_nw == ew, "R9 word total", g_nw, ew);
        nz = 0;
        for (int j = 0; j < g_nw && j < 4096; j++) if (got_w[j] != 0) nz++;
        check(nz == 0, "R9 zero substitute", nz, 0);
        check(!g_ready_empty, "R9 ready low while empty", g_ready_empty, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) wsrc[i] = (i * 2469 + 967) % 4096;
        for (int k = 0; k < 10240; k++) bsrc[k] = (k * 37 + 11) % 256;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #5;
        check(!busy && !done, "R11 reset busy/done", {busy, done}, 0);
        check(!w_in_ready && !b_out_valid && !b_in_ready && !w_out_valid,
              "R11 reset streams", {w_in_ready, b_out_valid, b_in_ready, w_out_valid}, 0);
        check(xfer_words == 0 && xfer_bytes == 0, "R11 reset plan", int'(xfer_words), 0);

        // R2 and R9: packed-mode sizing sweep from an empty source
        for (int n = 1; n <= 180; n++) do_empty(0, n, 0, "R2 sizing");
        do_empty(0, 4096, 0, "R2 sizing at 4096");

        // R1 and R3: byte mode, word limit vs track limit
        do_empty(1, 4096, 0, "R1 full count");
        do_empty(1, 300, 0, "R3 word limited");
        do_empty(1, 4096, 38, "R3 track limited");
        do_empty(1, 4096, 39, "R3 last sector");
        do_empty(1, 4096, 40, "R3 past track");
        do_empty(1, 5, 63, "R3 past track");

        // R4 R6: packed writes
        do_write(0, 1, 0, 0);
        do_write(0, 2, 0, 0);
        do_write(0, 3, 0, 0);
        do_write(0, 5, 0, 0);
        do_write(0, 170, 0, 0);
        do_write(0, 171, 0, 0);
        // R5: byte-mode writes
        do_write(1, 5, 0, 0);
        do_write(1, 300, 0, 0);
        do_write(1, 600, 39, 0);
        // R10: start during a transfer is ignored
        do_write(0, 20, 0, 1);
        check(g_xw == 20, "R10 plan kept after stray start", g_xw, 20);

        // R7 and R8: reads
        do_read(0, 1, 0);
        do_read(0, 2, 0);
        do_read(0, 5, 0);
        do_read(0, 170, 0);
        do_read(0, 171, 0);
        do_read(1, 7, 0);
        do_read(1, 260, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule